// File: doc/BRIEF.md
# Multi-size shift and rotate unit

This execution unit moves the bits of one register operand by one or two positions, in one of eight ways: arithmetic, logical or circular, to the left or to the right, and circular through the carry flag. The operand width is picked per operation as 8, 16 or 32 bits. Only the low field of the chosen width is changed. Every bit above that field leaves the unit exactly as it came in, so the result can go straight back into the destination register.

The transformation is combinational. The result and four condition flags (carry, zero, negative, overflow) are captured in output registers on the clock edge at which the input strobe is high. A pipeline controller drives one request per cycle with the strobe and collects the registered result one cycle later. An asynchronous active-low reset clears every output.

Top module: `shrot_unit`

## Requirements
- R1: When `in_valid` is 1 at a rising clock edge, that edge loads the result and flags into the output registers and `out_valid` is 1 for the following cycle. When `in_valid` is 0 at an edge, `out_valid` becomes 0 and `out_result` and all flags keep their values.
- R2: `in_size` selects the field: 0 is byte (bits 7:0), 1 is word (bits 15:0), 2 is longword (bits 31:0). The bits of `in_opnd` above the field appear unchanged in `out_result`.
- R3: `in_two` = 0 moves the field by one position and `in_two` = 1 moves it by two. A two-position operation gives the same result and flags as two one-position operations in a row, with the carry from the first feeding the second.
- R4: `in_op` = 0 is an arithmetic left shift that fills with zero. `in_op` = 1 is an arithmetic right shift that copies the field's sign bit into each vacated top position.
- R5: `in_op` = 2 is a logical left shift and `in_op` = 3 is a logical right shift. Both fill vacated positions with zero.
- R6: `in_op` = 4 rotates left and `in_op` = 5 rotates right within the field. A bit that leaves one end of the field enters at the other end.
- R7: `in_op` = 6 rotates left through carry and `in_op` = 7 rotates right through carry. The incoming carry `in_carry` fills the vacated position, and the bit pushed out becomes the new carry.
- R8: `out_c` is the last bit shifted or rotated out of the field, for all eight operations.
- R9: `out_z` is 1 exactly when the field of the result is all zeros. `out_n` equals the top bit of the field of the result.
- R10: For `in_op` = 0, `out_v` is 1 when any bit shifted out, or the new top bit of the field, differs from the original top bit. For every other operation `out_v` is 0.
- R11: While `rst_n` is 0, `out_valid`, `out_result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the outputs |
| in_opnd | input | 32 | Operand (destination register contents) |
| in_op | input | 3 | Operation select (0 to 7, see R4 to R7) |
| in_size | input | 2 | Field width: 0 byte, 1 word, 2 longword |
| in_two | input | 1 | 0: one position, 1: two positions |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 32 | Registered result |
| out_c | output | 1 | Carry flag |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Negative flag |
| out_v | output | 1 | Overflow flag |

## Verification
Each result and all four flags are due exactly one rising edge after the edge that samples the request, and `out_valid` marks that cycle. The driver applies each request on a falling edge and pushes the value computed by its own bit-serial model into a queue. The monitor samples on every falling edge and pops one entry each time `out_valid` is 1, so back-to-back requests line up with their results without any fixed delay counted in the bench. The hold and reset checks are made several idle cycles after the last result has been popped, so they never overlap a result that is still pending.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int NSZ    = 3;                  // byte, word, longword
  localparam int DATA_W = 8 << (NSZ - 1);     // widest field

  typedef enum logic [2:0] {
    OP_SAL = 3'd0, OP_SAR = 3'd1, OP_SLL = 3'd2, OP_SLR = 3'd3,
    OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RCL = 3'd6, OP_RCR = 3'd7
  } shrot_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_X = 2'd3
  } shrot_sz_e;
endpackage

// File: rtl/shrot_step.sv
// One single-position move of the selected field; upper bits pass through.
module shrot_step
  import shrot_pkg::*;
(
  input  logic [DATA_W-1:0] d,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              cin,
  output logic [DATA_W-1:0] q,
  output logic              cout,
  output logic              sflip
);
  shrot_op_e op_e;
  shrot_sz_e sz_e;
  assign op_e = shrot_op_e'(op);
  assign sz_e = shrot_sz_e'(size);

  logic [DATA_W-1:0] q_sz  [NSZ];
  logic              co_sz [NSZ];
  logic              fl_sz [NSZ];

  generate
    for (genvar g = 0; g < NSZ; g++) begin : g_sz
      localparam int W = 8 << g;
      logic [W-1:0] f;
      logic [W-1:0] r;
      logic         c;

      assign f = d[W-1:0];

      always_comb begin
        case (op_e)
          OP_SAL, OP_SLL: begin r = {f[W-2:0], 1'b0};    c = f[W-1]; end
          OP_SAR:         begin r = {f[W-1], f[W-1:1]};  c = f[0];   end
          OP_SLR:         begin r = {1'b0, f[W-1:1]};    c = f[0];   end
          OP_ROL:         begin r = {f[W-2:0], f[W-1]};  c = f[W-1]; end
          OP_ROR:         begin r = {f[0], f[W-1:1]};    c = f[0];   end
          OP_RCL:         begin r = {f[W-2:0], cin};     c = f[W-1]; end
          default:        begin r = {cin, f[W-1:1]};     c = f[0];   end
        endcase
      end

      if (W < DATA_W) begin : g_keep
        assign q_sz[g] = {d[DATA_W-1:W], r};
      end else begin : g_full
        assign q_sz[g] = r;
      end
      assign co_sz[g] = c;
      assign fl_sz[g] = r[W-1] ^ f[W-1];
    end
  endgenerate

  always_comb begin
    case (sz_e)
      SZ_B:    begin q = q_sz[0]; cout = co_sz[0]; sflip = fl_sz[0]; end
      SZ_W:    begin q = q_sz[1]; cout = co_sz[1]; sflip = fl_sz[1]; end
      default: begin q = q_sz[2]; cout = co_sz[2]; sflip = fl_sz[2]; end
    endcase
  end
endmodule

// File: rtl/shrot_path.sv
// Two chained single-position steps; the count picks the tap.
module shrot_path
  import shrot_pkg::*;
(
  input  logic [DATA_W-1:0] opnd,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              two,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              flip_a,
  output logic              flip_b
);
  logic [DATA_W-1:0] q0, q1;
  logic              c0, c1;
  logic              f0, f1;

  shrot_step u_step0 (
    .d(opnd), .op(op), .size(size), .cin(cin),
    .q(q0), .cout(c0), .sflip(f0)
  );

  shrot_step u_step1 (
    .d(q0), .op(op), .size(size), .cin(c0),
    .q(q1), .cout(c1), .sflip(f1)
  );

  always_comb begin
    res    = two ? q1 : q0;
    cout   = two ? c1 : c0;
    flip_a = f0;
    flip_b = two & f1;
  end
endmodule

// File: rtl/shrot_flags.sv
// Zero, negative and overflow from the sized result.
module shrot_flags
  import shrot_pkg::*;
(
  input  logic [DATA_W-1:0] res,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              flip_a,
  input  logic              flip_b,
  output logic              z,
  output logic              n,
  output logic              v
);
  shrot_sz_e sz_e;
  assign sz_e = shrot_sz_e'(size);

  logic zs [NSZ];
  logic ns [NSZ];

  generate
    for (genvar g = 0; g < NSZ; g++) begin : g_fl
      localparam int W = 8 << g;
      assign zs[g] = ~|res[W-1:0];
      assign ns[g] = res[W-1];
    end
  endgenerate

  always_comb begin
    case (sz_e)
      SZ_B:    begin z = zs[0]; n = ns[0]; end
      SZ_W:    begin z = zs[1]; n = ns[1]; end
      default: begin z = zs[2]; n = ns[2]; end
    endcase
    // sign changes at either step of an arithmetic left shift
    v = (shrot_op_e'(op) == OP_SAL) & (flip_a | flip_b);
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic              in_two,
  input  logic              in_carry,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_c,
  output logic              out_z,
  output logic              out_n,
  output logic              out_v
);
  logic [DATA_W-1:0] path_res;
  logic              path_c, flip_a, flip_b;
  logic              fz, fn, fv;

  shrot_path u_path (
    .opnd(in_opnd), .op(in_op), .size(in_size), .two(in_two), .cin(in_carry),
    .res(path_res), .cout(path_c), .flip_a(flip_a), .flip_b(flip_b)
  );

  shrot_flags u_flags (
    .res(path_res), .op(in_op), .size(in_size),
    .flip_a(flip_a), .flip_b(flip_b),
    .z(fz), .n(fn), .v(fv)
  );

  // next-state
  logic [DATA_W-1:0] res_d;
  logic              c_d, z_d, n_d, v_d;

  always_comb begin
    res_d = out_result;
    c_d   = out_c;
    z_d   = out_z;
    n_d   = out_n;
    v_d   = out_v;
    if (in_valid) begin
      res_d = path_res;
      c_d   = path_c;
      z_d   = fz;
      n_d   = fn;
      v_d   = fv;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_c      <= 1'b0;
      out_z      <= 1'b0;
      out_n      <= 1'b0;
      out_v      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_d;
        out_c      <= c_d;
        out_z      <= z_d;
        out_n      <= n_d;
        out_v      <= v_d;
      end
    end
  end

  // R1: strobe gives a result one cycle later
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: no strobe, outputs hold
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_c)
                   && $stable(out_z) && $stable(out_n) && $stable(out_v)));

  // R2: bits above a byte field pass through
  p_upper_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=>
      out_result[DATA_W-1:8] == $past(in_opnd[DATA_W-1:8]));

  // R4: arithmetic right on longword keeps the sign in the top two bits
  p_sar_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd1 && in_size == 2'd2) |=>
      (out_result[DATA_W-1] == $past(in_opnd[DATA_W-1]) &&
       out_result[DATA_W-2] == $past(in_opnd[DATA_W-1])));

  // R5: logical left leaves a zero at bit 0
  p_fill_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2) |=> out_result[0] == 1'b0);

  // R6: longword rotate keeps the number of ones
  p_rot_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2:1] == 2'b10 && in_size == 2'd2) |=>
      $countones(out_result) == $countones($past(in_opnd)));

  // R7: longword rotate through carry keeps the ones of operand plus carry
  p_rcx_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2:1] == 2'b11 && in_size == 2'd2) |=>
      $countones({out_c, out_result}) == $countones({$past(in_carry), $past(in_opnd)}));

  // R9: negative flag on a longword follows the result's top bit
  p_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd2) |=> out_n == out_result[DATA_W-1]);

  // R10: only the arithmetic left shift can raise overflow
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 3'd0) |=> !out_v);
endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_opnd;
  logic [2:0]  in_op;
  logic [1:0]  in_size;
  logic        in_two;
  logic        in_carry;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_c, out_z, out_n, out_v;

  always #10 clk = ~clk;   // 50 MHz

  shrot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_op(in_op), .in_size(in_size), .in_two(in_two), .in_carry(in_carry),
    .out_valid(out_valid), .out_result(out_result),
    .out_c(out_c), .out_z(out_z), .out_n(out_n), .out_v(out_v)
  );

  typedef struct {
    logic [31:0] res;
    logic        c, z, n, v;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] last_res = '0;
  logic [3:0]  last_fl  = '0;

  // bit-serial reference built from the requirements
  function automatic exp_t model(logic [31:0] a, logic [2:0] op, logic [1:0] sz,
                                 logic two, logic ci, string tag);
    exp_t e;
    int   w;
    logic [31:0] f;
    logic c, v, s0, ob, ib, anyz;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    f  = a;
    c  = ci;
    v  = 1'b0;
    s0 = a[w-1];
    for (int k = 0; k < (two ? 2 : 1); k++) begin
      if (op[0] == 1'b0) begin
        ob = f[w-1];
        case (op)
          3'd4:    ib = f[w-1];
          3'd6:    ib = c;
          default: ib = 1'b0;
        endcase
        for (int i = w - 1; i > 0; i--) f[i] = f[i-1];
        f[0] = ib;
      end else begin
        ob = f[0];
        case (op)
          3'd1:    ib = f[w-1];
          3'd5:    ib = f[0];
          3'd7:    ib = c;
          default: ib = 1'b0;
        endcase
        for (int i = 0; i < w - 1; i++) f[i] = f[i+1];
        f[w-1] = ib;
      end
      c = ob;
      if (ob != s0) v = 1'b1;
    end
    if (f[w-1] != s0) v = 1'b1;
    if (op != 3'd0) v = 1'b0;
    anyz = 1'b1;
    for (int i = 0; i < w; i++) if (f[i]) anyz = 1'b0;
    e.res = f;
    e.c   = c;
    e.z   = anyz;
    e.n   = f[w-1];
    e.v   = v;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [31:0] a, logic [2:0] op, logic [1:0] sz,
                      logic two, logic ci, string tag);
    @(negedge clk);
    in_opnd  = a;
    in_op    = op;
    in_size  = sz;
    in_two   = two;
    in_carry = ci;
    in_valid = 1'b1;
    sb_q.push_back(model(a, op, sz, two, ci, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk(logic ok, string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected out_valid got=%h exp=none", out_result);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (out_result !== e.res || out_c !== e.c || out_z !== e.z ||
              out_n !== e.n || out_v !== e.v) begin
            fails++;
            $display("FAIL %s got res=%h c=%b z=%b n=%b v=%b exp res=%h c=%b z=%b n=%b v=%b",
                     e.tag, out_result, out_c, out_z, out_n, out_v,
                     e.res, e.c, e.z, e.n, e.v);
          end
          last_res = e.res;
          last_fl  = {e.c, e.z, e.n, e.v};
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_opnd  = '0;
    in_op    = '0;
    in_size  = '0;
    in_two   = 1'b0;
    in_carry = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({out_valid, out_result, out_c, out_z, out_n, out_v} == '0, "R11 reset state",
        {out_c, out_z, out_n, out_v, out_result}, 36'h0);
    rst_n = 1'b1;

    // R4 arithmetic shifts
    send(32'h0000_0040, 3'd0, 2'd0, 1'b0, 1'b0, "R4 R10 sal byte into sign");
    send(32'h0000_8001, 3'd1, 2'd1, 1'b1, 1'b0, "R4 sar word by two");
    send(32'h1234_00F0, 3'd1, 2'd0, 1'b1, 1'b0, "R4 R2 sar byte upper kept");
    // R5 logical shifts
    send(32'hC000_0001, 3'd2, 2'd2, 1'b1, 1'b0, "R5 R8 shll long by two");
    send(32'hABCD_EF81, 3'd3, 2'd0, 1'b1, 1'b1, "R5 R2 shlr byte");
    send(32'h0000_0080, 3'd2, 2'd0, 1'b0, 1'b0, "R9 zero result byte");
    // R6 plain rotates
    send(32'h0000_0081, 3'd4, 2'd0, 1'b1, 1'b0, "R6 rotl byte by two");
    send(32'h0000_0001, 3'd5, 2'd2, 1'b0, 1'b0, "R6 R9 rotr long wraps to sign");
    send(32'hFFFF_8000, 3'd5, 2'd1, 1'b1, 1'b0, "R6 R2 rotr word upper kept");
    // R7 rotates through carry
    send(32'h0000_8000, 3'd6, 2'd1, 1'b1, 1'b1, "R7 R3 rcl word by two");
    send(32'h0000_0001, 3'd7, 2'd0, 1'b1, 1'b0, "R7 R3 rcr byte by two");
    send(32'h8000_0000, 3'd6, 2'd2, 1'b0, 1'b0, "R7 R8 rcl long carry out");
    // R10 overflow corners
    send(32'h2000_0000, 3'd0, 2'd2, 1'b1, 1'b0, "R10 sal result sign flips");
    send(32'hC000_0000, 3'd0, 2'd2, 1'b1, 1'b0, "R10 sal second bit lost");
    send(32'hE000_0000, 3'd0, 2'd2, 1'b1, 1'b0, "R10 sal no overflow");
    send(32'h0000_4000, 3'd0, 2'd1, 1'b0, 1'b0, "R10 sal word overflow");
    send(32'h0000_0080, 3'd3, 2'd0, 1'b0, 1'b0, "R10 shlr clears v");
    idle(4);

    // R1: hold after idle cycles
    chk(!out_valid && out_result == last_res && {out_c, out_z, out_n, out_v} == last_fl,
        "R1 outputs hold while idle", {out_c, out_z, out_n, out_v, out_result},
        {last_fl, last_res});

    // R3 and all others: broad random mix, back-to-back
    for (int i = 0; i < 600; i++) begin
      send($urandom, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 2)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R3 R8 R9 random mix");
      if (i % 7 == 6) idle(1);
    end
    idle(4);
    chk(!out_valid && out_result == last_res, "R1 hold after random run",
        {4'h0, out_result}, {4'h0, last_res});
    chk(sb_q.size() == 0, "R1 every request answered", 36'(sb_q.size()), 36'h0);

    // R11: asynchronous reset mid-cycle
    #3 rst_n = 1'b0;
    #2;
    chk({out_valid, out_result, out_c, out_z, out_n, out_v} == '0, "R11 reset clears outputs",
        {out_c, out_z, out_n, out_v, out_result}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    send(32'h0000_0003, 3'd4, 2'd2, 1'b1, 1'b0, "R11 R6 works after reset");
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule